// File: doc/BRIEF.md
# Repeated Word Majority Voter

This block sits behind a frame synchronizer on a narrowband data receiver. After each valid sync, the same message word is sent up to five times, and the copies may be interleaved with other traffic. The synchronizer pulses `sync_pulse` and then marks each bit slot that belongs to this word with `bit_en`. The block shifts each copy in, keeps a 3-bit count of ones for every bit position, and when it has the fifth copy it produces a bit-wise majority word with a one-cycle `word_valid` strobe.

An early-decision mode (`early_mode`) accepts the word as soon as the third or fourth copy matches the two copies before it. In that case the block raises `rx_off` so that the receiver front end can be powered down for the copies that remain. A frame timer counts bit periods (`bit_tick`) from sync. The limit is 463 in control mode and 920 in voice mode, and the mode is latched at sync. If the timer expires before five copies have been collected, the block issues a vote over the copies it has, with `word_partial` set, or it issues nothing when fewer than three copies arrived.

The controller has three states. ST_IDLE waits for sync. ST_COLLECT gathers copies. ST_RXOFF holds the power-down hint. The transitions are:
- SYNC_START: ST_IDLE to ST_COLLECT.
- RESTART: any state to ST_COLLECT on `sync_pulse`.
- FULL_DONE: ST_COLLECT to ST_IDLE on the fifth copy.
- EARLY_HIT: ST_COLLECT to ST_RXOFF.
- TIMEOUT: ST_COLLECT or ST_RXOFF to ST_IDLE on timer expiry.
- SLOTS_DONE: ST_RXOFF to ST_IDLE when the skipped copies' bit slots have passed.

Top module: `mvote_top`

## Requirements
- R1: After reset `word_valid`, `word_partial` and `rx_off` are 0 and `word_out` is all zeros.
- R2: When the fifth copy completes, `word_out` bit i is 1 exactly when at least 3 of the 5 copies had a 1 in that bit. The first received bit of a copy is the MSB (bit WORD_W-1). `word_valid` pulses high for one cycle, in the cycle after the edge that captured the last bit, with `word_partial` = 0.
- R3: A `sync_pulse` in any state discards all copies and partial bits and restarts the collection and the timer. A data bit presented in the same cycle as `sync_pulse` is not taken.
- R4: With `early_mode` = 1, when the 3rd or 4th copy is identical to the two copies before it, that copy is output with `word_valid` = 1 and `word_partial` = 0, and `rx_off` rises in the same cycle.
- R5: `rx_off` stays high until (5 − k)·WORD_W further slots with `bit_tick` = `bit_en` = 1 have passed, where k is the number of copies taken. It falls after the edge that counts the last of these slots. Bits seen while `rx_off` is high are ignored.
- R6: With `early_mode` = 0, or when no three consecutive copies are identical, no output is given before the fifth copy, and `rx_off` stays 0.
- R7: The timer counts `bit_tick` cycles after sync. It expires on the 463rd tick when `voice_mode` was 0 at sync, and on the 920th tick when it was 1.
- R8: On expiry with 3 completed copies, each output bit needs at least 2 ones. With 4 copies, each output bit needs at least 3 ones. `word_valid` and `word_partial` both pulse high.
- R9: On expiry with fewer than 3 copies there is no output, and the block returns to idle.
- R10: Slots with `bit_en` = 0, bits received outside a collection, and the bits of a copy that is still incomplete at expiry do not affect any vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pulse | input | 1 | Valid sync seen; start a new collection |
| voice_mode | input | 1 | 1 = voice-channel timeout (920), 0 = control (463); latched at sync |
| early_mode | input | 1 | Enable the three-identical-copies early decision |
| bit_tick | input | 1 | One bit period elapsed |
| bit_en | input | 1 | The bit in this period belongs to the word being voted |
| bit_in | input | 1 | Serial data bit |
| word_out | output | WORD_W | Voted word, held until the next result |
| word_valid | output | 1 | One-cycle strobe: `word_out` updated |
| word_partial | output | 1 | With `word_valid`: result came from a timeout with 3 or 4 copies |
| rx_off | output | 1 | Receiver may be powered down |

## Verification
The hardest situation to reach is a timeout that arrives while a copy is only partly received, after three or four whole copies. Only then do the incomplete-copy bits and the reduced vote threshold matter together. The stimulus sends three whole copies and then 20 bits of a fourth in control mode, and then runs idle ticks past 463. In voice mode it sends four copies spread over more than 463 ticks, with stretches where `bit_tick` is low, so that the 920 limit is counted in bit periods and not in clock cycles. A behavioural reference model holds the copies in a queue and is compared against the outputs on every cycle.

// File: rtl/mvote_pkg.sv
package mvote_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_RXOFF   = 2'd2
    } mv_state_e;

    localparam int unsigned MV_COPIES = 5;
endpackage

// File: rtl/mvote_bit_counters.sv
module mvote_bit_counters #(
    parameter int unsigned WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [WORD_W-1:0] add_vec,
    input  logic [2:0]        thr,
    output logic [WORD_W-1:0] vote
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        logic [2:0] cnt;
        logic [3:0] sum;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt <= '0;
            else if (clear)
                cnt <= '0;
            else if (add && add_vec[i])
                cnt <= cnt + 3'd1;
        end

        assign sum     = {1'b0, cnt} + {3'b000, add & add_vec[i]};
        assign vote[i] = (sum >= {1'b0, thr});

        assert_cnt_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= 3'd5);
    end
endmodule

// File: rtl/mvote_frame_timer.sv
module mvote_frame_timer #(
    parameter int unsigned TMO_VOICE = 920,
    parameter int unsigned TMO_CTRL  = 463
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic voice_sel,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int unsigned TMO_MAX = (TMO_VOICE > TMO_CTRL) ? TMO_VOICE : TMO_CTRL;
    localparam int unsigned TW      = $clog2(TMO_MAX + 1);

    logic [TW-1:0] cnt;
    logic          voice_q;
    logic [TW-1:0] lim_m1;

    assign lim_m1 = voice_q ? TW'(TMO_VOICE - 1) : TW'(TMO_CTRL - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            voice_q <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            voice_q <= voice_sel;
        end else if (run && tick && cnt != lim_m1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && tick && !start && (cnt == lim_m1);

    assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_m1);
endmodule

// File: rtl/mvote_repeat_buf.sv
module mvote_repeat_buf #(
    parameter int unsigned WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_in,
    output logic              complete,
    output logic [WORD_W-1:0] new_word,
    output logic              triple_match
);
    localparam int unsigned IW = $clog2(WORD_W);

    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] prev1;
    logic [WORD_W-1:0] prev2;
    logic [IW-1:0]     idx;

    assign new_word     = {cur[WORD_W-2:0], bit_in};
    assign complete     = shift && (idx == IW'(WORD_W - 1));
    assign triple_match = (new_word == prev1) && (prev1 == prev2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            prev1 <= '0;
            prev2 <= '0;
            idx   <= '0;
        end else if (clear) begin
            cur   <= '0;
            prev1 <= '0;
            prev2 <= '0;
            idx   <= '0;
        end else if (shift) begin
            cur <= new_word;
            if (complete) begin
                idx   <= '0;
                prev2 <= prev1;
                prev1 <= new_word;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IW'(WORD_W - 1));
endmodule

// File: rtl/mvote_top.sv
module mvote_top
    import mvote_pkg::*;
#(
    parameter int unsigned WORD_W    = 40,
    parameter int unsigned TMO_VOICE = 920,
    parameter int unsigned TMO_CTRL  = 463
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_pulse,
    input  logic              voice_mode,
    input  logic              early_mode,
    input  logic              bit_tick,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              word_partial,
    output logic              rx_off
);
    localparam int unsigned RW = $clog2(2 * WORD_W + 1);

    mv_state_e         state, state_n;
    logic [2:0]        rep_cnt;
    logic [2:0]        eff_reps;
    logic [RW-1:0]     remain_q;
    logic              accept, slot, complete, triple, expire;
    logic              full_done, early_hit, tmo_out;
    logic [2:0]        thr;
    logic [WORD_W-1:0] new_word, vote;

    assign slot   = bit_tick && bit_en;
    assign accept = slot && (state == ST_COLLECT) && !sync_pulse;

    mvote_repeat_buf #(.WORD_W(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(sync_pulse), .shift(accept),
        .bit_in(bit_in), .complete(complete), .new_word(new_word),
        .triple_match(triple)
    );

    mvote_bit_counters #(.WORD_W(WORD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(sync_pulse), .add(complete),
        .add_vec(new_word), .thr(thr), .vote(vote)
    );

    mvote_frame_timer #(.TMO_VOICE(TMO_VOICE), .TMO_CTRL(TMO_CTRL)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(sync_pulse), .voice_sel(voice_mode),
        .run(state != ST_IDLE), .tick(bit_tick), .expire(expire)
    );

    assign eff_reps  = rep_cnt + {2'b00, complete};
    assign thr       = (eff_reps >= 3'd4) ? 3'd3 : 3'd2;
    assign full_done = complete && (rep_cnt == 3'(MV_COPIES - 1));
    assign early_hit = complete && early_mode && triple &&
                       (rep_cnt == 3'd2 || rep_cnt == 3'd3);
    assign tmo_out   = expire && (eff_reps >= 3'd3);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (sync_pulse) state_n = ST_COLLECT;             // SYNC_START
            end
            ST_COLLECT: begin
                if (sync_pulse)     state_n = ST_COLLECT;         // RESTART
                else if (full_done) state_n = ST_IDLE;            // FULL_DONE
                else if (early_hit) state_n = ST_RXOFF;           // EARLY_HIT
                else if (expire)    state_n = ST_IDLE;            // TIMEOUT
            end
            ST_RXOFF: begin
                if (sync_pulse)                       state_n = ST_COLLECT; // RESTART
                else if (slot && remain_q == RW'(1))  state_n = ST_IDLE;    // SLOTS_DONE
                else if (expire)                      state_n = ST_IDLE;    // TIMEOUT
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // copy count and skipped-slot counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_cnt  <= '0;
            remain_q <= '0;
        end else if (sync_pulse) begin
            rep_cnt  <= '0;
            remain_q <= '0;
        end else begin
            if (state_n != ST_COLLECT)
                rep_cnt <= '0;
            else if (complete)
                rep_cnt <= rep_cnt + 3'd1;

            if (state == ST_COLLECT && early_hit)
                remain_q <= (rep_cnt == 3'd2) ? RW'(2 * WORD_W) : RW'(WORD_W);
            else if (state == ST_RXOFF && slot)
                remain_q <= remain_q - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out     <= '0;
            word_valid   <= 1'b0;
            word_partial <= 1'b0;
        end else begin
            word_valid   <= 1'b0;
            word_partial <= 1'b0;
            if (state == ST_COLLECT && !sync_pulse) begin
                if (full_done) begin
                    word_out   <= vote;
                    word_valid <= 1'b1;
                end else if (early_hit) begin
                    word_out   <= new_word;
                    word_valid <= 1'b1;
                end else if (tmo_out) begin
                    word_out     <= vote;
                    word_valid   <= 1'b1;
                    word_partial <= 1'b1;
                end
            end
        end
    end

    assign rx_off = (state == ST_RXOFF);

    assert_rxoff_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_off) |-> (word_valid && !word_partial));
    assert_partial_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_partial |-> word_valid);
    assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sync_pulse) |=> !word_valid);
    assert_rxoff_remain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RXOFF) |-> (remain_q != '0));
    assert_rep_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rep_cnt <= 3'd4);
endmodule

// File: tb/mvote_top_test.sv
module mvote_top_test;
    localparam int W = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_pulse = 1'b0, voice_mode = 1'b0, early_mode = 1'b0;
    logic         bit_tick = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
    logic [W-1:0] word_out;
    logic         word_valid, word_partial, rx_off;

    int checks = 0;
    int failures = 0;
    string req = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    mvote_top #(.WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .voice_mode(voice_mode),
        .early_mode(early_mode), .bit_tick(bit_tick), .bit_en(bit_en), .bit_in(bit_in),
        .word_out(word_out), .word_valid(word_valid), .word_partial(word_partial),
        .rx_off(rx_off)
    );

    // behavioural reference model
    logic [W-1:0] reps[$];
    logic [W-1:0] m_cur;
    int m_state = 0, m_nbits = 0, m_timer = 0, m_lim = 463, m_remain = 0;
    logic [W-1:0] e_word = '0;
    logic e_valid = 0, e_part = 0;

    function automatic logic [W-1:0] maj(int thr);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) begin
            int n = 0;
            foreach (reps[k]) n += reps[k][b];
            r[b] = (n >= thr);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; e_word = '0; e_valid = 0; e_part = 0; reps.delete();
        end else begin
            e_valid = 0; e_part = 0;
            if (sync_pulse) begin
                m_state = 1; reps.delete(); m_nbits = 0; m_timer = 0;
                m_lim = voice_mode ? 920 : 463;
            end else if (m_state == 1) begin
                bit comp = 0;
                if (bit_tick) m_timer++;
                if (bit_tick && bit_en) begin
                    m_cur = {m_cur[W-2:0], bit_in}; m_nbits++;
                    if (m_nbits == W) begin reps.push_back(m_cur); m_nbits = 0; comp = 1; end
                end
                if (comp && reps.size() == 5) begin
                    e_word = maj(3); e_valid = 1; m_state = 0;
                end else if (comp && early_mode && reps.size() >= 3 &&
                             reps[$] == reps[$-1] && reps[$-1] == reps[$-2]) begin
                    e_word = reps[$]; e_valid = 1; m_state = 2;
                    m_remain = (5 - reps.size()) * W;
                end else if (bit_tick && m_timer == m_lim) begin
                    m_state = 0;
                    if (reps.size() >= 3) begin
                        e_word = maj(reps.size() >= 4 ? 3 : 2); e_valid = 1; e_part = 1;
                    end
                end
            end else if (m_state == 2) begin
                if (bit_tick) m_timer++;
                if (bit_tick && bit_en) begin
                    m_remain--;
                    if (m_remain == 0) m_state = 0;
                end
                if (m_state == 2 && bit_tick && m_timer == m_lim) m_state = 0;
            end
        end
    end

    task automatic chk(logic [W-1:0] act, logic [W-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(W'(word_valid), W'(e_valid), "word_valid");
            chk(W'(word_partial), W'(e_part), "word_partial");
            chk(W'(rx_off), W'(m_state == 2), "rx_off");
            chk(word_out, e_word, "word_out");
        end
    end

    task automatic drive(logic s, logic t, logic e, logic b);
        @(negedge clk);
        #1;
        sync_pulse = s; bit_tick = t; bit_en = e; bit_in = b;
    endtask

    task automatic do_sync(logic voice);
        voice_mode = voice;
        drive(1'b1, 1'b1, 1'b1, 1'b1);   // R3: bit with sync is discarded
    endtask

    task automatic send_word(logic [W-1:0] w, int gap);
        for (int i = 0; i < W; i++) drive(1'b0, 1'b1, 1'b1, w[W-1-i]);
        for (int g = 0; g < gap; g++) drive(1'b0, 1'b1, 1'b0, g[0]);  // R10: bit_en low
    endtask

    task automatic idle_ticks(int n, bit sparse);
        for (int i = 0; i < n; i++) drive(1'b0, sparse ? i[0] : 1'b1, 1'b0, 1'b1);
    endtask

    function automatic logic [W-1:0] mkw(int s);
        return W'(64'h9E3779B97F4A7C15 * longint'(s + 1)) ^ W'(s * 7919);
    endfunction

    initial begin
        logic [W-1:0] a, b, c;
        repeat (3) @(negedge clk);
        checks++;
        if (word_valid !== 0 || word_partial !== 0 || rx_off !== 0 || word_out !== '0) begin
            failures++;
            $display("FAIL R1 reset outputs act=%b%b%b exp=000", word_valid, word_partial, rx_off);
        end
        rst_n = 1'b1;

        // R10: bits while idle are ignored
        req = "R10"; send_word(mkw(9), 3);

        // R2: five copies, mixed bit errors; bit 0 flipped in three copies
        req = "R2"; a = mkw(1); do_sync(0);
        send_word(a ^ 40'h1 ^ (40'h1 << 39), 10); send_word(a ^ 40'h1 ^ (40'h1 << 5), 10);
        send_word(a, 10); send_word(a ^ 40'h1 ^ (40'h1 << 5), 10);
        send_word(a ^ (40'h1 << 39), 4);

        // R6: early off, three identical copies do not end the collection
        req = "R6"; b = mkw(2); do_sync(0);
        send_word(a, 5); send_word(a, 5); send_word(a, 5); send_word(b, 5); send_word(b, 5);
        // R6: early on but no three identical consecutive
        early_mode = 1; do_sync(0);
        send_word(a, 5); send_word(b, 5); send_word(a, 5); send_word(b, 5); send_word(a, 5);

        // R4/R5: early at copy 3, two skipped copies
        req = "R4"; c = mkw(3); do_sync(0);
        send_word(c, 6); send_word(c, 6); send_word(c, 6);
        req = "R5"; send_word(mkw(4), 6); send_word(mkw(5), 6);
        // R4: early at copy 4
        req = "R4"; do_sync(0);
        send_word(b, 3); send_word(c, 3); send_word(c, 3); send_word(c, 3);
        req = "R5"; send_word(a, 3); idle_ticks(5, 0);

        // R3: restart mid collection and during rx_off
        req = "R3"; do_sync(0); send_word(a, 2); send_word(a, 2); idle_ticks(7, 0);
        do_sync(0); send_word(c, 2); send_word(c, 2); send_word(c, 2); send_word(b, 2);
        do_sync(0); send_word(b, 2); send_word(a, 2); send_word(b, 2); send_word(a, 2);
        send_word(a, 2);
        early_mode = 0;

        // R7/R8/R10: control timeout with 3 copies and a partial fourth
        req = "R8"; do_sync(0);
        send_word(a, 7); send_word(b, 7); send_word(c ^ 40'hF0F, 7);
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b1, 1'b1, 1'b1);
        req = "R7"; idle_ticks(500, 0);

        // R7/R8: voice timeout with 4 copies, sparse ticks
        req = "R7"; do_sync(1);
        send_word(a, 100); send_word(b, 100); send_word(a ^ 40'h3, 100); send_word(c, 100);
        req = "R8"; idle_ticks(1200, 1);

        // R9: timeout with two copies, no output
        req = "R9"; do_sync(0); send_word(a, 30); send_word(a, 30); idle_ticks(480, 0);
        req = "R10"; send_word(b, 2);

        idle_ticks(10, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        checks++; failures++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule